// File: doc/BRIEF.md
# Byte Parity Check and Generate Unit

This unit sits on one port of a dual-clock buffer and handles parity for 36-bit words organised as four 9-bit bytes. Each byte carries its parity in its top bit. On the incoming bus it checks every byte and drops an active-low error flag, registered once on the port clock, when any byte fails. On the outgoing side it can replace the top bit of each byte with freshly computed parity, both for words leaving the buffer array (captured in the port output register) and for the mailbox word presented on a mailbox read.

One odd/even select governs both checking and generation. A single set of four parity trees serves both the input check and mailbox generation, so while a mailbox read with generation is selected the trees look at the mailbox word and the error flag is held inactive. The buffer array path has its own trees ahead of the output register, so its generated parity is fixed at the clock edge that loads the register. Storage itself lives outside: this unit never alters the mailbox word it is given.

Top module: `bp_port`

## Requirements
- R1: A word is four bytes at bits [8:0], [17:9], [26:18] and [35:27]; the parity bit of each byte is its top bit (bits 8, 17, 26, 35), and the lower eight bits of every byte pass to the output unchanged on every path.
- R2: `perr_n` is registered: at each rising clock edge it becomes 0 if any byte of `bus_in` fails parity and 1 if all bytes pass; it reflects the bus value present at that edge.
- R3: With `odd_sel` = 1 a byte passes when its 9 bits hold an odd number of ones; with `odd_sel` = 0 it passes when they hold an even number of ones.
- R4: When a mailbox read with generation is selected (`cs_n`=0, `en`=1, `wr_nrd`=0, `mb_sel`=1, `gen_en`=1) at a clock edge, `perr_n` becomes 1 at that edge whatever `bus_in` holds.
- R5: With `mb_sel`=1, `dout` shows `mail_word`; during a mailbox read with generation the four parity bits are replaced by parity of each byte's lower eight bits per `odd_sel`, otherwise all 36 bits are shown as given. This is combinational.
- R6: At a rising edge with `fifo_load`=1 the output register captures `fifo_word`; if `gen_en`=1 at that edge the four parity bits are replaced by generated parity using `odd_sel` at that edge. `dout` shows the register when `mb_sel`=0.
- R7: While `fifo_load`=0 the output register holds; changing `gen_en` or `odd_sel` after the load has no effect on it.
- R8: Synchronous reset (`rst`=1) sets `perr_n` to 1 and the output register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| gen_en | input | 1 | Enable parity generation on reads |
| cs_n | input | 1 | Port select, active low |
| en | input | 1 | Port transfer enable |
| wr_nrd | input | 1 | 1 = write, 0 = read |
| mb_sel | input | 1 | 1 = mailbox, 0 = buffer array |
| bus_in | input | 36 | Incoming bus data to check |
| mail_word | input | 36 | Contents of the mailbox register being read |
| fifo_word | input | 36 | Word read from the buffer array |
| fifo_load | input | 1 | Load the output register this edge |
| dout | output | 36 | Outgoing data word |
| perr_n | output | 1 | Parity error flag, active low, registered |

## Verification
The assertions take for granted that the control inputs are settled and known at each rising edge and that reset is applied for at least one edge before any other activity; the generated-parity check on `dout` assumes `odd_sel` does not change between the edge and the sampled mailbox output. The stimulus changes every input only at the falling edge and samples at the next falling edge, so each input is stable across the rising edge it is meant for and each registered result is read one edge later.

// File: rtl/bp_pkg.sv
package bp_pkg;
    parameter int NUM_BYTES = 4;
    parameter int BYTE_W    = 9;
    localparam int WORD_W   = NUM_BYTES * BYTE_W;
    localparam int DATA_W   = BYTE_W - 1;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [NUM_BYTES-1:0] pvec_t;

    typedef struct packed {
        logic cs_n;
        logic en;
        logic wr_nrd;
        logic mb_sel;
        logic gen_en;
    } port_ctl_t;

    // Replace the top bit of each byte with the matching bit of p.
    function automatic word_t merge_par(word_t w, pvec_t p);
        word_t r;
        r = w;
        for (int b = 0; b < NUM_BYTES; b++) begin
            r[b*BYTE_W + DATA_W] = p[b];
        end
        return r;
    endfunction

    // Gather the top bit of each byte.
    function automatic pvec_t top_bits(word_t w);
        pvec_t r;
        for (int b = 0; b < NUM_BYTES; b++) begin
            r[b] = w[b*BYTE_W + DATA_W];
        end
        return r;
    endfunction

    // Whole-byte count check, used by assertions only.
    function automatic logic word_par_ok(word_t w, logic odd);
        logic ok;
        ok = 1'b1;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if ((^w[b*BYTE_W +: BYTE_W]) != odd) ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/bp_tree.sv
module bp_tree
    import bp_pkg::*;
(
    input  word_t src,
    input  logic  odd_sel,
    output pvec_t par
);
    // One tree per byte: parity bit that makes the byte pass.
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign par[b] = (^src[b*BYTE_W +: DATA_W]) ^ odd_sel;
    end
endmodule

// File: rtl/bp_fifo_reg.sv
module bp_fifo_reg
    import bp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  gen_en,
    input  logic  odd_sel,
    input  word_t raw,
    output word_t q
);
    pvec_t gen_par;
    word_t next_w;

    bp_tree i_tree (
        .src     (raw),
        .odd_sel (odd_sel),
        .par     (gen_par)
    );

    assign next_w = gen_en ? merge_par(raw, gen_par) : raw;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= next_w;
    end

    a_r7_hold_when_idle : assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
    a_r6_raw_capture : assert property (@(posedge clk) disable iff (rst)
        (load && !gen_en) |=> (q == $past(raw)));
    a_r6_gen_capture : assert property (@(posedge clk) disable iff (rst)
        (load && gen_en) |=> word_par_ok(q, $past(odd_sel)));
endmodule

// File: rtl/bp_port.sv
module bp_port
    import bp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        odd_sel,
    input  logic        gen_en,
    input  logic        cs_n,
    input  logic        en,
    input  logic        wr_nrd,
    input  logic        mb_sel,
    input  logic [35:0] bus_in,
    input  logic [35:0] mail_word,
    input  logic [35:0] fifo_word,
    input  logic        fifo_load,
    output logic [35:0] dout,
    output logic        perr_n
);
    port_ctl_t ctl;
    logic      mail_gen;
    word_t     tree_src;
    pvec_t     tree_par;
    pvec_t     byte_fail;
    word_t     mail_out;
    word_t     fifo_q;

    assign ctl = '{cs_n: cs_n, en: en, wr_nrd: wr_nrd, mb_sel: mb_sel, gen_en: gen_en};
    assign mail_gen = !ctl.cs_n && ctl.en && !ctl.wr_nrd && ctl.mb_sel && ctl.gen_en;

    // Shared trees: bus check normally, mailbox generation when selected.
    assign tree_src = mail_gen ? word_t'(mail_word) : word_t'(bus_in);

    bp_tree i_shared_tree (
        .src     (tree_src),
        .odd_sel (odd_sel),
        .par     (tree_par)
    );

    assign byte_fail = tree_par ^ top_bits(word_t'(bus_in));

    always_ff @(posedge clk) begin
        if (rst)           perr_n <= 1'b1;
        else if (mail_gen) perr_n <= 1'b1;
        else               perr_n <= ~|byte_fail;
    end

    assign mail_out = mail_gen ? merge_par(word_t'(mail_word), tree_par) : word_t'(mail_word);

    bp_fifo_reg i_out_reg (
        .clk     (clk),
        .rst     (rst),
        .load    (fifo_load),
        .gen_en  (gen_en),
        .odd_sel (odd_sel),
        .raw     (word_t'(fifo_word)),
        .q       (fifo_q)
    );

    assign dout = mb_sel ? mail_out : fifo_q;

    a_r4_mask_on_mail_gen : assert property (@(posedge clk) disable iff (rst)
        mail_gen |=> perr_n);
    a_r2_clean_bus_no_error : assert property (@(posedge clk) disable iff (rst)
        word_par_ok(word_t'(bus_in), odd_sel) |=> perr_n);
    a_r5_mail_generated : assert property (@(posedge clk) disable iff (rst)
        mail_gen |-> word_par_ok(dout, odd_sel));
    a_r1_low_bits_kept : assert property (@(posedge clk) disable iff (rst)
        mb_sel |-> ((dout & ~merge_par('0, '1)) == (word_t'(mail_word) & ~merge_par('0, '1))));
    a_r8_reset_state : assert property (@(posedge clk)
        rst |=> (perr_n && fifo_q == '0));
endmodule

// File: tb/test_bp_port.sv
module test_bp_port;
    logic        clk = 1'b0;
    logic        rst, odd_sel, gen_en, cs_n, en, wr_nrd, mb_sel, fifo_load;
    logic [35:0] bus_in, mail_word, fifo_word, dout;
    logic        perr_n;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bp_port i_bp_port (
        .clk(clk), .rst(rst), .odd_sel(odd_sel), .gen_en(gen_en), .cs_n(cs_n),
        .en(en), .wr_nrd(wr_nrd), .mb_sel(mb_sel), .bus_in(bus_in),
        .mail_word(mail_word), .fifo_word(fifo_word), .fifo_load(fifo_load),
        .dout(dout), .perr_n(perr_n)
    );

    // Reference: word with parity bits set so every byte passes.
    function automatic logic [35:0] ref_fix(logic [35:0] w, logic odd);
        logic [35:0] r = w;
        for (int b = 0; b < 4; b++) r[b*9+8] = (^w[b*9 +: 8]) ^ odd;
        return r;
    endfunction

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1; en = 0; wr_nrd = 1; mb_sel = 0; gen_en = 0; fifo_load = 0;
    endtask

    // Drive bus at falling edge, check flag after next rising edge.
    task automatic bus_flag(string req, logic [35:0] w, logic odd, logic exp);
        @(negedge clk); bus_in = w; odd_sel = odd;
        @(negedge clk); chk(req, {35'd0, perr_n}, {35'd0, exp});
    endtask

    task automatic t_reset();
        rst = 1; idle(); odd_sel = 1; bus_in = '0; mail_word = '0; fifo_word = 36'hFFFFFFFFF;
        repeat (2) @(negedge clk);
        chk("R8 flag", {35'd0, perr_n}, 36'd1);
        chk("R8 reg", dout, 36'd0);
        rst = 0;
    endtask

    task automatic t_check();
        logic [35:0] good = ref_fix(36'h3A5C_1F07E, 1'b1);
        bus_flag("R3 odd good", good, 1'b1, 1'b1);
        bus_flag("R3 odd zero word fails", 36'd0, 1'b1, 1'b0);
        bus_flag("R3 even zero word passes", 36'd0, 1'b0, 1'b1);
        bus_flag("R3 even word under odd", ref_fix(36'h123456789, 1'b0), 1'b1, 1'b0);
        for (int b = 0; b < 4; b++) begin
            bus_flag("R1 single byte error", good ^ (36'd1 << (b*9+8)), 1'b1, 1'b0);
            bus_flag("R2 data bit error", good ^ (36'd1 << (b*9+3)), 1'b1, 1'b0);
        end
        bus_flag("R2 recovers", good, 1'b1, 1'b1);
    endtask

    task automatic t_mail();
        @(negedge clk);
        mail_word = 36'h5A5A5A5A5; odd_sel = 1; bus_in = 36'd0;
        cs_n = 0; en = 1; wr_nrd = 0; mb_sel = 1; gen_en = 1;
        #1 chk("R5 mail generated", dout, ref_fix(36'h5A5A5A5A5, 1'b1));
        @(negedge clk);
        chk("R4 flag masked", {35'd0, perr_n}, 36'd1);
        odd_sel = 0;
        #1 chk("R5 mail even", dout, ref_fix(36'h5A5A5A5A5, 1'b0));
        chk("R5 mail word unchanged", mail_word, 36'h5A5A5A5A5);
        gen_en = 0;
        #1 chk("R5 raw mail", dout, 36'h5A5A5A5A5);
        odd_sel = 1;
        @(negedge clk);
        chk("R4 no mask without gen", {35'd0, perr_n}, 36'd0);
        gen_en = 1; cs_n = 1;
        #1 chk("R5 deselected raw", dout, 36'h5A5A5A5A5);
        idle();
    endtask

    task automatic t_fifo();
        @(negedge clk);
        fifo_word = 36'hF0E1D2C3B; gen_en = 0; fifo_load = 1; odd_sel = 1;
        @(negedge clk); fifo_load = 0;
        chk("R6 raw load", dout, 36'hF0E1D2C3B);
        fifo_word = 36'h000000000; gen_en = 1; fifo_load = 1; odd_sel = 0;
        @(negedge clk); fifo_load = 0; fifo_word = 36'hFFFFFFFFF;
        chk("R6 even generated", dout, ref_fix(36'h0, 1'b0));
        fifo_word = 36'h9876543AB; fifo_load = 1; odd_sel = 1;
        @(negedge clk); fifo_load = 0; gen_en = 0; odd_sel = 0;
        chk("R6 odd generated", dout, ref_fix(36'h9876543AB, 1'b1));
        @(negedge clk);
        chk("R7 hold after control change", dout, ref_fix(36'h9876543AB, 1'b1));
        idle();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_check();
                t_mail();
                t_fifo();
            end
            begin
                repeat (5000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule